// File: doc/BRIEF.md
# Next Program Counter Selection Unit

This block owns the program counter of a single-cycle 32-bit RISC core and decides, once per clock, which address the core fetches next. It is fed the fetched instruction word, the Branch and Jump bits from the decoder and the Zero flag from the ALU. It returns the registered program counter and the incremented address (program counter plus four), which the rest of the core also uses.

Three candidate addresses are formed every cycle. The sequential source (SEQ) is the incremented address. The branch source (BRANCH) adds the sign-extended low 16 bits of the instruction, scaled to words, to the incremented address. The jump source (JUMP) keeps the top four bits of the incremented address and fills the rest with the 26-bit index field followed by two zero bits. A chooser names one source per cycle. JUMP is taken whenever Jump is high. Otherwise BRANCH is taken when Branch and Zero are both high. In every other case SEQ is taken. The program counter loads the chosen address on the next rising edge.

Top module: `pc_next_unit`

## Requirements
- R1: A high `rst` sampled at a rising edge sets `pc_q` to 0x00000000 on that edge, whatever the other inputs are.
- R2: `pc_plus4` always equals `pc_q` + 4, taken modulo 2^32, in the same cycle.
- R3: With `jump_en`=0 and `branch_en`=0, the next `pc_q` is `pc_plus4`. Neither `alu_zero` nor any instruction bit changes this.
- R4: With `jump_en`=0, `branch_en`=1 and `alu_zero`=0, the branch is not taken and the next `pc_q` is `pc_plus4`.
- R5: With `jump_en`=0, `branch_en`=1 and `alu_zero`=1, the next `pc_q` is `pc_plus4` + (sign-extended `instr[15:0]` × 4), modulo 2^32. Bit 15 is the sign, so 0xFFFF gives a next address equal to the current one.
- R6: With `jump_en`=1, the next `pc_q` is {`pc_plus4[31:28]`, `instr[25:0]`, 2'b00}.
- R7: When `jump_en`=1, the jump source is taken even if `branch_en`=1 and `alu_zero`=1.
- R8: The four region bits of a jump target come from `pc_plus4`, not from `pc_q`. From `pc_q`=0x0FFFFFFC, a jump with index 0 goes to 0x10000000.
- R9: Outside reset, `pc_q[1:0]` is always 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Fetched instruction word: offset in [15:0], jump index in [25:0] |
| branch_en | input | 1 | Decoder branch control bit |
| jump_en | input | 1 | Decoder jump control bit |
| alu_zero | input | 1 | ALU result-is-zero flag |
| pc_q | output | 32 | Registered program counter |
| pc_plus4 | output | 32 | Program counter plus four |

## Verification
A taken branch and a jump can arrive in the same cycle. When they do, the chooser has to pick JUMP over BRANCH. The bench provokes this with one vector that raises Jump, Branch and Zero together, with an instruction whose offset field and index field lead to different addresses. The result is judged correct only if the next `pc_q` equals the jump target from its reference model and not the branch target.

// File: rtl/pcsel_pkg.sv
package pcsel_pkg;

    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_JUMP   = 2'd2
    } npc_src_e;

    localparam int WORD_SHIFT = 2;

endpackage

// File: rtl/pcsel_seq_adder.sv
module pcsel_seq_adder #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] pc_cur,
    output logic [ADDR_W-1:0] pc_inc
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    always_comb begin
        pc_inc = pc_cur + STEP_V;
    end
endmodule

// File: rtl/pcsel_branch_target.sv
module pcsel_branch_target #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 2
) (
    input  logic [ADDR_W-1:0] pc_inc,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - OFF_W - SHIFT;

    logic [ADDR_W-1:0] scaled;

    generate
        if (EXT_W > 0) begin : g_ext
            always_comb begin
                scaled = {{EXT_W{offset[OFF_W-1]}}, offset, {SHIFT{1'b0}}};
            end
        end else begin : g_trunc
            logic [OFF_W+SHIFT-1:0] wide;
            always_comb begin
                wide   = {offset, {SHIFT{1'b0}}};
                scaled = wide[ADDR_W-1:0];
            end
        end
    endgenerate

    always_comb begin
        target = pc_inc + scaled;
    end
endmodule

// File: rtl/pcsel_jump_splice.sv
module pcsel_jump_splice #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 26,
    parameter int SHIFT  = 2
) (
    input  logic [ADDR_W-1:0] pc_inc,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] target
);
    localparam int REGION_W = ADDR_W - IDX_W - SHIFT;

    generate
        if (REGION_W > 0) begin : g_region
            always_comb begin
                target = {pc_inc[ADDR_W-1 -: REGION_W], index, {SHIFT{1'b0}}};
            end
        end else begin : g_flat
            logic [IDX_W+SHIFT-1:0] wide;
            logic [ADDR_W-1:0]      unused_inc;
            always_comb begin
                unused_inc = pc_inc;
                wide       = {index, {SHIFT{1'b0}}};
                target     = wide[ADDR_W-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/pcsel_chooser.sv
module pcsel_chooser
    import pcsel_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              branch_en,
    input  logic              jump_en,
    input  logic              alu_zero,
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic [ADDR_W-1:0] br_addr,
    input  logic [ADDR_W-1:0] jmp_addr,
    output npc_src_e          src,
    output logic [ADDR_W-1:0] next_pc
);
    logic take_branch;

    always_comb begin
        take_branch = branch_en & alu_zero;
        unique case ({jump_en, take_branch})
            2'b10, 2'b11: src = SRC_JUMP;
            2'b01:        src = SRC_BRANCH;
            default:      src = SRC_SEQ;
        endcase
    end

    always_comb begin
        unique case (src)
            SRC_JUMP:   next_pc = jmp_addr;
            SRC_BRANCH: next_pc = br_addr;
            default:    next_pc = seq_addr;
        endcase
    end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
    import pcsel_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          INSTR_W  = 32,
    parameter int          OFF_W    = 16,
    parameter int          IDX_W    = 26,
    parameter int          STEP     = 4,
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr,
    input  logic               branch_en,
    input  logic               jump_en,
    input  logic               alu_zero,
    output logic [ADDR_W-1:0]  pc_q,
    output logic [ADDR_W-1:0]  pc_plus4
);
    logic [ADDR_W-1:0] br_addr;
    logic [ADDR_W-1:0] jmp_addr;
    logic [ADDR_W-1:0] next_pc;
    npc_src_e          src;

    pcsel_seq_adder #(.ADDR_W(ADDR_W), .STEP(STEP)) i_seq (
        .pc_cur (pc_q),
        .pc_inc (pc_plus4)
    );

    pcsel_branch_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SHIFT(WORD_SHIFT)) i_br (
        .pc_inc (pc_plus4),
        .offset (instr[OFF_W-1:0]),
        .target (br_addr)
    );

    pcsel_jump_splice #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SHIFT(WORD_SHIFT)) i_jmp (
        .pc_inc (pc_plus4),
        .index  (instr[IDX_W-1:0]),
        .target (jmp_addr)
    );

    pcsel_chooser #(.ADDR_W(ADDR_W)) i_choose (
        .branch_en (branch_en),
        .jump_en   (jump_en),
        .alu_zero  (alu_zero),
        .seq_addr  (pc_plus4),
        .br_addr   (br_addr),
        .jmp_addr  (jmp_addr),
        .src       (src),
        .next_pc   (next_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= ADDR_W'(RESET_PC);
        end else begin
            pc_q <= next_pc;
        end
    end
endmodule

// File: rtl/pc_next_unit_chk.sv
module pc_next_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] instr,
    input logic        branch_en,
    input logic        jump_en,
    input logic        alu_zero,
    input logic [31:0] pc_q,
    input logic [31:0] pc_plus4
);
    // R1
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> pc_q == 32'h0);

    // R3
    a_r3_sequential: assert property (@(posedge clk) disable iff (rst)
        (!jump_en && !branch_en) |=> pc_q == $past(pc_plus4));

    // R4
    a_r4_not_taken: assert property (@(posedge clk) disable iff (rst)
        (!jump_en && branch_en && !alu_zero) |=> pc_q == $past(pc_plus4));

    // R5
    a_r5_taken: assert property (@(posedge clk) disable iff (rst)
        (!jump_en && branch_en && alu_zero) |=>
        pc_q == $past(pc_plus4) + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

    // R6, R8
    a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
        jump_en |=> pc_q == {$past(pc_plus4[31:28]), $past(instr[25:0]), 2'b00});

    // R7
    a_r7_jump_wins: assert property (@(posedge clk) disable iff (rst)
        (jump_en && branch_en && alu_zero) |=>
        pc_q[27:2] == $past(instr[25:0]));

    // R9
    a_r9_aligned: assert property (@(posedge clk) disable iff (rst)
        $past(rst) == 1'b0 |-> pc_q[1:0] == 2'b00);
endmodule

bind pc_next_unit pc_next_unit_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .instr     (instr),
    .branch_en (branch_en),
    .jump_en   (jump_en),
    .alu_zero  (alu_zero),
    .pc_q      (pc_q),
    .pc_plus4  (pc_plus4)
);

// File: tb/test_pc_next_unit.sv
module test_pc_next_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0;
    logic        branch_en = 1'b0;
    logic        jump_en = 1'b0;
    logic        alu_zero = 1'b0;
    logic [31:0] pc_q;
    logic [31:0] pc_plus4;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] model_pc = '0;

    always #4 clk = ~clk;

    pc_next_unit i_pc_next_unit (
        .clk(clk), .rst(rst), .instr(instr), .branch_en(branch_en),
        .jump_en(jump_en), .alu_zero(alu_zero), .pc_q(pc_q), .pc_plus4(pc_plus4)
    );

    // vector: {jump, branch, zero, instr}
    localparam int NV = 9;
    localparam logic [34:0] VEC [NV] = '{
        {3'b001, 32'h1234_5678},  // R3 zero ignored
        {3'b010, 32'h0000_0010},  // R4 not taken
        {3'b011, 32'h0000_0010},  // R5 forward
        {3'b011, 32'h0000_FFF0},  // R5 backward
        {3'b100, 32'h0800_0100},  // R6 jump
        {3'b111, 32'h0000_0ABC},  // R7 jump wins over taken branch
        {3'b000, 32'hFFFF_FFFF},  // R3 sequential
        {3'b011, 32'h0000_8000},  // R5 most negative, wraps
        {3'b100, 32'h02AB_CDEF}   // R6 region from high addresses
    };

    function automatic logic [31:0] ref_next(input logic [31:0] pc, input logic jp,
                                             input logic br, input logic z,
                                             input logic [31:0] ins);
        logic [31:0] inc;
        logic [31:0] off;
        inc = pc + 32'd4;
        off = 32'($signed(ins[15:0])) <<< 2;
        if (jp)          return {inc[31:28], ins[25:0], 2'b00};
        else if (br & z) return inc + off;
        else             return inc;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a negedge: drive, check increment, advance one edge, check pc
    task automatic step(input string req, input logic jp, input logic br,
                        input logic z, input logic [31:0] ins);
        jump_en = jp; branch_en = br; alu_zero = z; instr = ins;
        #1;
        check("R2", pc_plus4, model_pc + 32'd4);
        model_pc = ref_next(model_pc, jp, br, z, ins);
        @(negedge clk);
        check(req, pc_q, model_pc);
        check("R9", {30'd0, pc_q[1:0]}, 32'd0);
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1", pc_q, 32'h0);
        rst = 1'b0;
        model_pc = '0;

        for (int i = 0; i < NV; i++) begin
            step($sformatf("vector %0d R3/R4/R5/R6/R7", i),
                 VEC[i][34], VEC[i][33], VEC[i][32], VEC[i][31:0]);
        end

        // R1: reset mid-run beats a jump request
        jump_en = 1'b1; instr = 32'h03FF_FFFF; rst = 1'b1;
        @(negedge clk);
        check("R1", pc_q, 32'h0);
        rst = 1'b0;
        model_pc = '0;

        // R8: climb to top of low region, then jump with index 0
        step("R6", 1'b1, 1'b0, 1'b0, 32'h03FF_FFFF);
        check("R6", pc_q, 32'h0FFF_FFFC);
        step("R8", 1'b1, 1'b0, 1'b0, 32'h0000_0000);
        check("R8", pc_q, 32'h1000_0000);

        // R5: offset 0xFFFF taken keeps the address
        step("R5", 1'b0, 1'b1, 1'b1, 32'h0000_FFFF);
        check("R5", pc_q, 32'h1000_0000);

        // R7 directed: branch offset and jump index disagree
        step("R7", 1'b1, 1'b1, 1'b1, 32'h0000_0040);
        check("R7", pc_q, 32'h1000_0100);

        // R3: branch low, zero high, noisy instruction
        step("R3", 1'b0, 1'b0, 1'b1, 32'hDEAD_BEEF);
        check("R3", pc_q, 32'h1000_0104);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule